// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block tunes the slew rate of a high-speed transmitter once, after start-up. A single start pulse launches a fixed sequence. It raises the calibration enable and lets it settle for one millisecond. It then switches on a free-running measurement clock, programs the window of an internal frequency meter and starts it. The meter is polled at one-millisecond intervals, up to a bounded number of times. The sequence then shuts everything down in the reverse order and settles for one more millisecond.

When the meter returns a count F, the block computes a rounded reciprocal with one shared sequential divider, used in two passes. The first pass gives floor(819200 / F). The second adds 500 and divides by 1000. The low three bits of the result become the slew-control code. If no count arrives before the poll limit, the code falls back to 4.

The internal meter compares two clock inputs that are sampled in the system clock domain. It counts rising edges of the measured clock during a window of reference-clock rising edges. Every delay is expressed as a number of system-clock cycles per millisecond (`CYC_PER_MS`).

Top module: `srcal_seq`

## Requirements
- R1: After reset, busy_o, done_o, cal_en_o and frck_en_o are 0 and code_o is 4.
- R2: A start_i pulse sampled while idle sets busy_o and cal_en_o on the next clock edge. frck_en_o rises exactly CYC_PER_MS cycles after cal_en_o rises.
- R3: The meter window is loaded with WIN_LEN (1024 by default) after frck_en_o rises. The meter is enabled only after that load, and only while frck_en_o is 1.
- R4: The meter result is 0 until the window of WIN_LEN reference rising edges has completed. It then holds the number of measured-clock rising edges counted in that window, with a minimum of 1.
- R5: The first poll happens in the first cycle the meter is enabled, and later polls follow every CYC_PER_MS cycles, up to POLLS (10) polls in total. A nonzero result ends polling at once. If all POLLS reads are zero, the block waits one more CYC_PER_MS and declares a timeout. In that case frck_en_o stays high for at least POLLS*CYC_PER_MS cycles.
- R6: Teardown runs in a fixed order: the meter is disabled; frck_en_o falls on the next edge; cal_en_o falls one edge after that; a CYC_PER_MS settle wait follows.
- R7: With a count F, code_o becomes the low 3 bits of floor((floor(819200/F)+500)/1000). For example, F=1365 gives 1, F=512 gives 2, F=128 gives 6, F=64 gives 5 (13 truncated) and F=1 gives 3 (819 truncated).
- R8: After a timeout, code_o becomes 4.
- R9: done_o is high for exactly one cycle, in the last cycle of busy_o, and code_o already holds its final value in that cycle. code_o does not change while idle.
- R10: start_i is ignored while busy_o is 1, including the done_o cycle. Such a pulse never starts another run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, honoured only while idle |
| ref_clk_i | input | 1 | Reference clock that defines the meter window |
| meas_clk_i | input | 1 | Free-running clock being measured |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cal_en_o | output | 1 | Slew-rate calibration enable |
| frck_en_o | output | 1 | Free-running measurement clock enable |
| code_o | output | 3 | Slew-control code |

## Verification
Two functions can meet in one cycle: the completion pulse and a new start request, since a pulse arriving while done_o is high finds the sequencer still busy. The bench drives start_i exactly in the cycle where it sees done_o high. It then requires busy_o to stay low on the following cycles and code_o to keep its value. A second start pulse is also injected as the measurement clock switches on. That run must still produce a single done pulse and no follow-on run. The meter result is hidden inside the block, so the measured frequencies are chosen so that a count error of one edge cannot change the expected code.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_CALW   = 4'd1,
    ST_FRCK   = 4'd2,
    ST_LOAD   = 4'd3,
    ST_POLL   = 4'd4,
    ST_OFFM   = 4'd5,
    ST_OFFF   = 4'd6,
    ST_SETTLE = 4'd7,
    ST_DIV1   = 4'd8,
    ST_DIV1W  = 4'd9,
    ST_DIV2   = 4'd10,
    ST_DIV2W  = 4'd11,
    ST_DONE   = 4'd12
  } srcal_state_e;

endpackage

// File: rtl/srcal_fmeter.sv
module srcal_fmeter #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned WIN_LEN = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             meas_clk_i,
  input  logic             load_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] res_o
);

  // two synchronizer stages plus one history stage per input
  logic [2:0] ref_s_q, meas_s_q;
  logic       ref_edge, meas_edge;

  logic [CNT_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] refc_q, refc_d;
  logic [CNT_W-1:0] measc_q, measc_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             fin_q, fin_d;
  logic [CNT_W-1:0] meas_total;
  logic             upd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_s_q  <= '0;
      meas_s_q <= '0;
    end else begin
      ref_s_q  <= {ref_s_q[1:0], ref_clk_i};
      meas_s_q <= {meas_s_q[1:0], meas_clk_i};
    end
  end

  assign ref_edge   = ref_s_q[1] & ~ref_s_q[2];
  assign meas_edge  = meas_s_q[1] & ~meas_s_q[2];
  assign meas_total = measc_q + CNT_W'(meas_edge);
  assign upd_en     = load_i | (en_i & ~fin_q);

  always_comb begin
    win_d   = win_q;
    refc_d  = refc_q;
    measc_d = measc_q;
    res_d   = res_q;
    fin_d   = fin_q;
    if (load_i) begin
      win_d   = CNT_W'(WIN_LEN);
      refc_d  = '0;
      measc_d = '0;
      res_d   = '0;
      fin_d   = 1'b0;
    end else begin
      measc_d = meas_total;
      if (ref_edge) begin
        if (refc_q + CNT_W'(1) >= win_q) begin
          fin_d = 1'b1;
          res_d = (meas_total == '0) ? CNT_W'(1) : meas_total;
        end else begin
          refc_d = refc_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      refc_q  <= '0;
      measc_q <= '0;
      res_q   <= '0;
      fin_q   <= 1'b0;
    end else if (upd_en) begin
      win_q   <= win_d;
      refc_q  <= refc_d;
      measc_q <= measc_d;
      res_q   <= res_d;
      fin_q   <= fin_d;
    end
  end

  assign res_o = res_q;

  // R4: completion is always visible as a nonzero result
  assert_result_nonzero_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fin_q) |-> (res_q != '0));

endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
  parameter int unsigned NUM_W = 20,
  parameter int unsigned DEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             valid_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int unsigned CW = $clog2(NUM_W + 1);
  localparam int unsigned PW = NUM_W + DEN_W + 1;

  logic [DEN_W:0]   rem_q, rem_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [NUM_W-1:0] num_q, num_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             valid_q, valid_d;
  logic [DEN_W:0]   shifted;
  logic             fits;

  assign shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den_q};

  always_comb begin
    rem_d   = rem_q;
    quo_d   = quo_q;
    num_d   = num_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    valid_d = 1'b0;
    if (start_i) begin
      rem_d = '0;
      quo_d = num_i;
      num_d = num_i;
      den_d = den_i;
      cnt_d = CW'(NUM_W);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = fits ? (shifted - {1'b0, den_q}) : shifted;
      quo_d = {quo_q[NUM_W-2:0], fits};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_d   = 1'b0;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      quo_q   <= '0;
      num_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      quo_q   <= quo_d;
      num_q   <= num_d;
      den_q   <= den_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign quo_o   = quo_q;

  // R7: a finished division satisfies quotient*divisor + remainder == dividend
  assert_div_exact_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (PW'(quo_q) * PW'(den_q) + PW'(rem_q) == PW'(num_q)));

endmodule

// File: rtl/srcal_ctrl.sv
module srcal_ctrl
  import srcal_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 60000,
  parameter int unsigned POLLS      = 10,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned NUM_W      = 20,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned SR_NUM     = 819200,
  parameter int unsigned ROUND_ADD  = 500,
  parameter int unsigned ROUND_DIV  = 1000,
  parameter int unsigned FALLBACK   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  fm_res_i,
  input  logic              div_valid_i,
  input  logic [NUM_W-1:0]  div_quo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cal_en_o,
  output logic              frck_en_o,
  output logic              fm_en_o,
  output logic              fm_load_o,
  output logic              div_start_o,
  output logic [NUM_W-1:0]  div_num_o,
  output logic [CNT_W-1:0]  div_den_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned TMR_W  = $clog2(CYC_PER_MS + 1);
  localparam int unsigned PIDX_W = $clog2(POLLS + 1);

  srcal_state_e      state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [PIDX_W-1:0] pidx_q, pidx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NUM_W-1:0]  q1_q, q1_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    state_d     = state_q;
    tmr_d       = tmr_q;
    pidx_d      = pidx_q;
    cnt_d       = cnt_q;
    q1_d        = q1_q;
    code_d      = code_q;
    code_en     = 1'b0;
    div_start_o = 1'b0;
    div_num_o   = '0;
    div_den_o   = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CALW;
        tmr_d   = TMR_W'(CYC_PER_MS - 1);
      end
      ST_CALW: begin
        if (tmr_q == '0) state_d = ST_FRCK;
        else             tmr_d   = tmr_q - TMR_W'(1);
      end
      ST_FRCK: state_d = ST_LOAD;
      ST_LOAD: begin
        state_d = ST_POLL;
        tmr_d   = '0;
        pidx_d  = '0;
        cnt_d   = '0;
      end
      ST_POLL: begin
        if (tmr_q != '0) begin
          tmr_d = tmr_q - TMR_W'(1);
        end else if (pidx_q == PIDX_W'(POLLS)) begin
          state_d = ST_OFFM;
        end else if (fm_res_i != '0) begin
          state_d = ST_OFFM;
          cnt_d   = fm_res_i;
        end else begin
          pidx_d = pidx_q + PIDX_W'(1);
          tmr_d  = TMR_W'(CYC_PER_MS - 1);
        end
      end
      ST_OFFM: state_d = ST_OFFF;
      ST_OFFF: begin
        state_d = ST_SETTLE;
        tmr_d   = TMR_W'(CYC_PER_MS - 1);
      end
      ST_SETTLE: begin
        if (tmr_q != '0) begin
          tmr_d = tmr_q - TMR_W'(1);
        end else if (cnt_q == '0) begin
          state_d = ST_DONE;
          code_en = 1'b1;
          code_d  = CODE_W'(FALLBACK);
        end else begin
          state_d = ST_DIV1;
        end
      end
      ST_DIV1: begin
        div_start_o = 1'b1;
        div_num_o   = NUM_W'(SR_NUM);
        div_den_o   = cnt_q;
        state_d     = ST_DIV1W;
      end
      ST_DIV1W: if (div_valid_i) begin
        q1_d    = div_quo_i + NUM_W'(ROUND_ADD);
        state_d = ST_DIV2;
      end
      ST_DIV2: begin
        div_start_o = 1'b1;
        div_num_o   = q1_q;
        div_den_o   = CNT_W'(ROUND_DIV);
        state_d     = ST_DIV2W;
      end
      ST_DIV2W: if (div_valid_i) begin
        code_en = 1'b1;
        code_d  = div_quo_i[CODE_W-1:0];
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      pidx_q  <= '0;
      cnt_q   <= '0;
      q1_q    <= '0;
      code_q  <= CODE_W'(FALLBACK);
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      pidx_q  <= pidx_d;
      cnt_q   <= cnt_d;
      q1_q    <= q1_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign cal_en_o  = (state_q inside {ST_CALW, ST_FRCK, ST_LOAD, ST_POLL, ST_OFFM, ST_OFFF});
  assign frck_en_o = (state_q inside {ST_FRCK, ST_LOAD, ST_POLL, ST_OFFM});
  assign fm_en_o   = (state_q == ST_POLL);
  assign fm_load_o = (state_q == ST_LOAD);
  assign code_o    = code_q;

  // R2: calibration enable only rises in answer to a start pulse
  assert_cal_on_start_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_en_o) |-> $past(start_i));

  // R6: the measurement clock never runs without calibration enable
  assert_frck_in_cal_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    frck_en_o |-> cal_en_o);

  // R6: the measurement clock drops after the meter, before the calibration enable
  assert_teardown_order_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frck_en_o) |-> (cal_en_o && !fm_en_o && $past(!fm_en_o)));

  // R9: done is a single-cycle pulse that ends the busy period
  assert_done_single_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R9: the code does not move while idle
  assert_code_stable_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(code_o));

  // R10: a start pulse while busy does not end the run early
  assert_start_ignored_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq #(
  parameter int unsigned CYC_PER_MS = 60000,
  parameter int unsigned WIN_LEN    = 1024,
  parameter int unsigned POLLS      = 10,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned SR_NUM     = 819200,
  parameter int unsigned ROUND_ADD  = 500,
  parameter int unsigned ROUND_DIV  = 1000,
  parameter int unsigned FALLBACK   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ref_clk_i,
  input  logic              meas_clk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cal_en_o,
  output logic              frck_en_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned NUM_W = $clog2(SR_NUM + ROUND_ADD + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             fm_en, fm_load;
  logic [CNT_W-1:0] fm_res;
  logic             div_start, div_valid;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [CNT_W-1:0] div_den;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  srcal_ctrl #(
    .CYC_PER_MS(CYC_PER_MS), .POLLS(POLLS), .CNT_W(CNT_W), .NUM_W(NUM_W),
    .CODE_W(CODE_W), .SR_NUM(SR_NUM), .ROUND_ADD(ROUND_ADD),
    .ROUND_DIV(ROUND_DIV), .FALLBACK(FALLBACK)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .fm_res_i    (fm_res),
    .div_valid_i (div_valid),
    .div_quo_i   (div_quo),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cal_en_o    (cal_en_o),
    .frck_en_o   (frck_en_o),
    .fm_en_o     (fm_en),
    .fm_load_o   (fm_load),
    .div_start_o (div_start),
    .div_num_o   (div_num),
    .div_den_o   (div_den),
    .code_o      (code_o)
  );

  srcal_fmeter #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_fmeter (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ref_clk_i  (ref_clk_i),
    .meas_clk_i (meas_clk_i),
    .load_i     (fm_load),
    .en_i       (fm_en),
    .res_o      (fm_res)
  );

  srcal_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .valid_o (div_valid),
    .quo_o   (div_quo)
  );

  // R3: the meter only runs while the measurement clock is enabled
  assert_meter_needs_frck_R3 : assert property (@(posedge clk_i) disable iff (!rst_n)
    fm_en |-> frck_en_o);

  // R3: the window is loaded in the cycle before the meter is first enabled
  assert_load_before_en_R3 : assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(fm_en) |-> $past(fm_load));

endmodule

// File: tb/srcal_seq_tb.sv
module srcal_seq_tb;

  localparam int CYC   = 1000;
  localparam int POLLS = 10;
  localparam int REF_HALF = 4;
  localparam int WIN   = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ref_clk = 1'b0;
  logic meas_clk = 1'b0;
  logic busy, done, cal_en, frck_en;
  logic [2:0] code;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  bit ref_run = 1'b0;
  int meas_half = 0;
  int rcnt = 0;
  int mcnt = 0;

  always #2 clk = ~clk;

  srcal_seq #(.CYC_PER_MS(CYC), .WIN_LEN(WIN), .POLLS(POLLS)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .ref_clk_i  (ref_clk),
    .meas_clk_i (meas_clk),
    .busy_o     (busy),
    .done_o     (done),
    .cal_en_o   (cal_en),
    .frck_en_o  (frck_en),
    .code_o     (code)
  );

  always @(posedge clk) begin
    if (ref_run) begin
      if (rcnt == REF_HALF - 1) begin rcnt <= 0; ref_clk <= ~ref_clk; end
      else rcnt <= rcnt + 1;
    end
    if (meas_half != 0) begin
      if (mcnt >= meas_half - 1) begin mcnt <= 0; meas_clk <= ~meas_clk; end
      else mcnt <= mcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int f);
    return (((819200 / f) + 500) / 1000) % 8;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R1 busy/done idle", int'(busy) + int'(done), 0);
    chk(!cal_en && !frck_en, "R1 enables off", int'(cal_en) + int'(frck_en), 0);
    chk(code == 3'd4, "R1 reset code", code, 4);
  endtask

  // one full calibration run; expc is the expected code
  task automatic t_run(input int mh, input bit rr, input int expc, input string nm,
                       input bit poke_mid, input bit poke_done);
    int n, m, d;
    logic [2:0] held;
    meas_half = mh;
    ref_run = rr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && cal_en && !frck_en, {"R2 start accepted ", nm}, int'(busy & cal_en), 1);
    n = 0;
    while (!frck_en && n < 3 * CYC) begin @(negedge clk); n++; end
    chk(n == CYC, {"R2 cal to frck delay ", nm}, n, CYC);
    if (poke_mid) begin start = 1'b1; @(negedge clk); start = 1'b0; m = 1; end
    else m = 0;
    while (frck_en && m < 20 * CYC) begin @(negedge clk); m++; end
    chk(cal_en, {"R6 cal held after frck off ", nm}, int'(cal_en), 1);
    if (rr) chk(m < POLLS * CYC, {"R5 completed before poll limit ", nm}, m, POLLS * CYC);
    else    chk(m >= POLLS * CYC, {"R5 timeout length ", nm}, m, POLLS * CYC);
    @(negedge clk);
    chk(!cal_en && busy, {"R6 cal off next cycle ", nm}, int'(cal_en), 0);
    d = 0;
    while (!done && d < 3 * CYC) begin @(negedge clk); d++; end
    chk(d >= CYC - 1, {"R6 settle wait ", nm}, d, CYC);
    chk(int'(code) == expc, {(rr ? "R7 code " : "R8 fallback code "), nm}, code, expc);
    held = code;
    if (poke_done) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, {"R9 single done pulse ", nm}, int'(done) + int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(!busy, {"R10 no restart after ignored start ", nm}, int'(busy), 0);
    chk(code == held, {"R9 code stable idle ", nm}, code, held);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    // F about 8192/6 = 1365 -> 1 (R7)
    t_run(3, 1'b1, exp_code(1365), "f1365", 1'b1, 1'b0);
    // F about 512 -> 2, start in done cycle (R10)
    t_run(8, 1'b1, exp_code(512), "f512", 1'b0, 1'b1);
    // F about 128 -> 6 (R7)
    t_run(32, 1'b1, exp_code(128), "f128", 1'b0, 1'b0);
    // F about 64 -> 13 truncated to 5 (R7)
    t_run(64, 1'b1, exp_code(64), "f64_trunc", 1'b0, 1'b0);
    // measured clock stuck: minimum count 1 -> 819 truncated to 3 (R4, R7)
    t_run(0, 1'b1, exp_code(1), "f1_min_R4", 1'b0, 1'b1);
    // reference stuck: meter never completes -> fallback 4 (R5, R8)
    t_run(8, 1'b0, 4, "timeout", 1'b1, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule